// File: doc/BRIEF.md
# Power Domain Shutdown and Restart Sequencer

This controller takes a clock/reset domain that sits behind register clock-crossing FIFOs down to zero power, and later brings it back up. Each side of those FIFOs has a traffic gate. A host asks for power-down with `off_req` and for power-up with `on_req`. The crossing reports whether register traffic is still outstanding through `inflight_busy`. The controller drives three signals: the traffic gate toward the crossing (`xing_allow`), the domain reset (`dom_rst`) and the domain power enable (`dom_pwr_en`). All three come from state decoded in one clock, so each one changes synchronously to that clock.

The power-down path runs in this order:
- Close the gate.
- Wait until the in-flight traffic has drained.
- Assert reset.
- Drop power.

The power-up path runs in this order:
- Restore power while reset is still held.
- Wait `SETTLE_CYCLES`.
- Release reset.
- Wait `SETTLE_CYCLES` again.
- Open the gate, as the final step.

A one-cycle `done` pulse marks the end of each sequence. A two-bit `status` output shows where the controller stands.

The states and their transitions are:
- `ST_ON` goes to `ST_DRAIN` when `off_req` is seen.
- `ST_DRAIN` goes to `ST_RESET` when `inflight_busy` is low.
- `ST_RESET` goes to `ST_OFF` after one cycle.
- `ST_OFF` goes to `ST_PWRUP` when `on_req` is seen.
- `ST_PWRUP` goes to `ST_RELEASE` when the settle timer expires.
- `ST_RELEASE` goes to `ST_ON` when the settle timer expires.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, the controller is in the ON state, with `xing_allow`=1, `dom_rst`=0, `dom_pwr_en`=1, `status`=2'b00 and `done`=0.
- R2: When `off_req` is high in a cycle in the ON state, the outputs after the next clock edge are `xing_allow`=0, `dom_rst`=0, `dom_pwr_en`=1 and `status`=2'b10 (powering down).
- R3: The controller stays in the drain step while `inflight_busy` is high. After the first edge that sees `inflight_busy` low, `dom_rst`=1 while `dom_pwr_en` is still 1, for exactly one cycle.
- R4: One edge after reset is asserted, `dom_pwr_en` goes to 0 with `dom_rst`=1 and `xing_allow`=0, and `status`=2'b01 (off).
- R5: When `on_req` is high in a cycle in the OFF state, the outputs after the next edge are `dom_pwr_en`=1, `dom_rst`=1, `xing_allow`=0 and `status`=2'b11 (powering up). These values hold for exactly `SETTLE_CYCLES` cycles.
- R6: `dom_rst` then goes to 0 while `xing_allow` stays 0, for exactly `SETTLE_CYCLES` cycles.
- R7: `xing_allow` then goes to 1 and `status` returns to 2'b00. This is the only way `xing_allow` rises.
- R8: The controller ignores a request in the following cases:
  - `on_req` while the controller is in the ON state.
  - `off_req` while the controller is in the OFF state.
  - Any request while a sequence is running.
- R9: `done` is high for exactly one cycle: the first cycle of the OFF state after a power-down, and the first cycle of the ON state after a power-up.
- R10: When `off_req` and `on_req` are both high in the ON state, the controller starts a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_req | input | 1 | Host request to power the domain down |
| on_req | input | 1 | Host request to power the domain up |
| inflight_busy | input | 1 | Register traffic still outstanding in the crossing |
| xing_allow | output | 1 | Traffic gate toward the crossing |
| dom_rst | output | 1 | Domain reset, active high |
| dom_pwr_en | output | 1 | Domain power enable |
| status | output | 2 | 00 on, 01 off, 10 powering down, 11 powering up |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Some properties are checked by assertions on every cycle:
- Power is only ever removed with reset already held.
- Reset is only ever released while power is up.
- The gate only ever opens after reset has been released.
- Reset is only ever asserted after a cycle with no in-flight traffic.
- `done` never lasts two cycles.

Other behaviour can only be shown by the bench's scripted scenarios:
- The exact lengths of the two settle windows.
- That requests are ignored in each state.
- The priority when both requests arrive together.
- The output values in every step.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        ST_ON      = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_RESET   = 3'd2,
        ST_OFF     = 3'd3,
        ST_PWRUP   = 3'd4,
        ST_RELEASE = 3'd5
    } pds_state_e;

    localparam logic [1:0] STAT_ON   = 2'b00;
    localparam logic [1:0] STAT_OFF  = 2'b01;
    localparam logic [1:0] STAT_DOWN = 2'b10;
    localparam logic [1:0] STAT_UP   = 2'b11;

endpackage

// File: rtl/pds_settle_timer.sv
module pds_settle_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles spent in a wait step; saturates at the last count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R5/R6 support: the counter never passes its last value
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off_req,
    input  logic       on_req,
    input  logic       inflight_busy,
    input  logic       settle_done,
    output logic       tmr_clr,
    output logic       tmr_run,
    output logic       xing_allow,
    output logic       dom_rst,
    output logic       dom_pwr_en,
    output logic [1:0] status,
    output logic       done
);
    pds_state_e state_q, state_d;
    logic       done_q;

    // State register and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ON;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ((state_q == ST_RESET) && (state_d == ST_OFF)) ||
                       ((state_q == ST_RELEASE) && (state_d == ST_ON));
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON:      if (off_req)        state_d = ST_DRAIN;
            ST_DRAIN:   if (!inflight_busy) state_d = ST_RESET;
            ST_RESET:                       state_d = ST_OFF;
            ST_OFF:     if (on_req)         state_d = ST_PWRUP;
            ST_PWRUP:   if (settle_done)    state_d = ST_RELEASE;
            ST_RELEASE: if (settle_done)    state_d = ST_ON;
            default:                        state_d = ST_ON;
        endcase
    end

    // Output decode
    always_comb begin
        xing_allow = 1'b0;
        dom_rst    = 1'b1;
        dom_pwr_en = 1'b1;
        status     = STAT_DOWN;
        tmr_run    = 1'b0;
        unique case (state_q)
            ST_ON: begin
                xing_allow = 1'b1;
                dom_rst    = 1'b0;
                status     = STAT_ON;
            end
            ST_DRAIN: begin
                dom_rst = 1'b0;
            end
            ST_RESET: begin
                status = STAT_DOWN;
            end
            ST_OFF: begin
                dom_pwr_en = 1'b0;
                status     = STAT_OFF;
            end
            ST_PWRUP: begin
                status  = STAT_UP;
                tmr_run = 1'b1;
            end
            ST_RELEASE: begin
                dom_rst = 1'b0;
                status  = STAT_UP;
                tmr_run = 1'b1;
            end
            default: begin
                status = STAT_DOWN;
            end
        endcase
    end

    assign tmr_clr = (state_d != state_q);
    assign done    = done_q;

    // R4: power only drops while reset was already held
    a_r4_rst_before_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_pwr_en) |-> ($past(dom_rst) && dom_rst));

    // R6: reset only released with power up for at least a cycle
    a_r6_release_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst) |-> (dom_pwr_en && $past(dom_pwr_en)));

    // R7: gate opens only after reset released and power present
    a_r7_allow_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xing_allow) |-> (!dom_rst && dom_pwr_en && !$past(dom_rst)));

    // R3: reset asserted only after a cycle with no in-flight traffic
    a_r3_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst) |-> $past(!inflight_busy));

    // R9: completion pulse is one cycle long
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: gate closed whenever the domain is unpowered or held in reset
    a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!dom_pwr_en || dom_rst) |-> !xing_allow);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off_req,
    input  logic       on_req,
    input  logic       inflight_busy,
    output logic       xing_allow,
    output logic       dom_rst,
    output logic       dom_pwr_en,
    output logic [1:0] status,
    output logic       done
);
    logic tmr_clr, tmr_run, settle_done;

    pds_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .off_req       (off_req),
        .on_req        (on_req),
        .inflight_busy (inflight_busy),
        .settle_done   (settle_done),
        .tmr_clr       (tmr_clr),
        .tmr_run       (tmr_run),
        .xing_allow    (xing_allow),
        .dom_rst       (dom_rst),
        .dom_pwr_en    (dom_pwr_en),
        .status        (status),
        .done          (done)
    );

    pds_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (settle_done)
    );

    initial begin
        a_r5_settle_param: assert (SETTLE_CYCLES >= 1);
    end

endmodule

// File: tb/tb_pwr_domain_seq.sv
module tb_pwr_domain_seq;
    localparam int S = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic off_req = 1'b0, on_req = 1'b0, inflight_busy = 1'b0;
    logic xing_allow, dom_rst, dom_pwr_en, done;
    logic [1:0] status;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pwr_domain_seq #(.SETTLE_CYCLES(S)) dut (
        .clk(clk), .rst_n(rst_n), .off_req(off_req), .on_req(on_req),
        .inflight_busy(inflight_busy), .xing_allow(xing_allow),
        .dom_rst(dom_rst), .dom_pwr_en(dom_pwr_en), .status(status),
        .done(done)
    );

    // Vector: {allow, rst, pwr, status[1:0], done}
    localparam logic [5:0] V_ON    = 6'b101_00_0;
    localparam logic [5:0] V_ONDN  = 6'b101_00_1;
    localparam logic [5:0] V_DRAIN = 6'b001_10_0;
    localparam logic [5:0] V_RST   = 6'b011_10_0;
    localparam logic [5:0] V_OFFDN = 6'b010_01_1;
    localparam logic [5:0] V_OFF   = 6'b010_01_0;
    localparam logic [5:0] V_PWRUP = 6'b011_11_0;
    localparam logic [5:0] V_REL   = 6'b001_11_0;

    // Driver: drive inputs at the falling edge, push expected outputs after the next rising edge
    task automatic step(input logic off, input logic on, input logic busy,
                        input logic [5:0] exp, input string tag);
        @(negedge clk);
        off_req = off;
        on_req = on;
        inflight_busy = busy;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare 1 ns after each rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        #1;
        if (exp_q.size() != 0) begin
            logic [5:0] e;
            logic [5:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {xing_allow, dom_rst, dom_pwr_en, status, done};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", t, a, e);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        wait (cycles > 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        finish_run();
    end

    initial begin
        // R1: reset values, checked directly before any edge
        #1;
        n_checks++;
        if ({xing_allow, dom_rst, dom_pwr_en, status, done} !== V_ON) begin
            n_fail++;
            $display("FAIL R1 in reset: got %b expected %b",
                     {xing_allow, dom_rst, dom_pwr_en, status, done}, V_ON);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, V_ON, "R1 idle after reset");
        step(0, 1, 0, V_ON, "R8 on_req ignored in ON");
        step(0, 0, 0, V_ON, "R8 still ON");
        // Power-down while traffic is pending
        step(1, 0, 1, V_DRAIN, "R2 gate closed");
        step(0, 1, 1, V_DRAIN, "R3 drain holds / R8 on_req ignored");
        step(0, 0, 1, V_DRAIN, "R3 drain holds");
        step(1, 0, 1, V_DRAIN, "R3 drain holds / R8 off_req ignored");
        step(0, 0, 0, V_RST, "R3 reset before power off");
        step(0, 1, 0, V_OFFDN, "R4 off with done / R8 on_req ignored in reset step");
        step(0, 0, 0, V_OFF, "R9 done one cycle");
        step(1, 0, 0, V_OFF, "R8 off_req ignored in OFF");
        // Power-up
        step(0, 1, 0, V_PWRUP, "R5 power on reset held");
        for (int i = 1; i < S; i++)
            step(i == 2, i == 3, 0, V_PWRUP, "R5 settle / R8 ignored");
        for (int i = 0; i < S; i++)
            step(i == 1, 0, 0, V_REL, "R6 reset released gate closed");
        step(0, 0, 0, V_ONDN, "R7 gate opened last, done");
        step(0, 0, 0, V_ON, "R9 done one cycle");
        // Both requests together, no traffic pending
        step(1, 1, 0, V_DRAIN, "R10 off wins");
        step(0, 0, 0, V_RST, "R10 reset step");
        step(0, 0, 0, V_OFFDN, "R10 off done");
        step(0, 0, 0, V_OFF, "R10 stays off");
        // Second power-up to confirm the timer restarts
        step(0, 1, 0, V_PWRUP, "R5 second power up");
        for (int i = 1; i < S; i++)
            step(0, 0, 0, V_PWRUP, "R5 second settle");
        for (int i = 0; i < S; i++)
            step(0, 0, 0, V_REL, "R6 second release");
        step(0, 0, 0, V_ONDN, "R7 second on");
        step(0, 0, 0, V_ON, "R1 back to idle");
        wait (exp_q.size() == 0);
        @(negedge clk);
        finish_run();
    end
endmodule